// File: doc/BRIEF.md
# Serial Host Register Read Port

This block is the slave side of a serial control port. A host microcontroller uses it to read back one word from the chip: a 16-bit coefficient memory word or a 24-bit setup register. The host clocks a command word into a data-in line on rising serial clock edges and then raises a latch strobe. For a read command the port pulls its ready line low, which tells the host to wait. At the same moment it enables its data-out driver and issues a one-cycle request to the internal storage. When the storage answers, the port raises ready and shifts the word out, least significant bit first, one bit per serial clock period.

All three host inputs are asynchronous to the system clock. They pass through two-flop synchronizers, and their edges are detected in the system clock domain. Serial timing is therefore expressed in system clock cycles. The command shift register samples data-in on every serial clock rise, including rises during a read. This lets the host send its next command while the current word is still shifting out, down to the case where the last read bit and the last command bit use the same edge. After the word has gone out, ready drops again and the driver is released. The latch strobe must not be lowered while a word is still shifting out. If it is, the port flags a sequencing error.

Top module: `srp_read_port`

## Requirements
- R1: After reset, ready is high, the data-out enable is low, and no request or error pulse is issued.
- R2: A read command is acted on at the rising latch strobe. Ready is still high at the second system clock edge after the strobe input goes high. Ready falls and the data-out enable rises together at the third edge.
- R3: A command is made of the last ADDR_W+2 bits sampled on serial clock rises before the latch strobe rises, sent most significant bit first. Bit one is read/write (1 = read). Bit two is the target (1 = 24-bit setup register, 0 = 16-bit coefficient word). The remaining ADDR_W bits are the address, most significant bit first. A read issues exactly one single-cycle request carrying that address and target bit.
- R4: Ready stays low until the storage signals valid. Ready is high right after the clock edge that samples valid.
- R5: The fetched word is shifted out least significant bit first. The length is 16 bits for target 0 and 24 bits for target 1. Each bit is updated after a serial clock fall and holds across the following rise.
- R6: Serial clock falls that occur while ready is low do not advance the output. The first bit is driven after the first fall that follows ready going high.
- R7: At the serial clock rise that follows the last data bit, ready goes low and the data-out enable is released.
- R8: Command bits shifted in while read data is going out, including a last command bit on the same edge as the last read bit, form a valid command for the next latch strobe.
- R9: A falling latch strobe while a word is shifting out produces a one-cycle error pulse. Falling strobes at any other time produce none.
- R10: A write command (read/write bit 0) issues no request, leaves ready high and keeps the data-out enable low.
- R11: After a read has ended, a falling latch strobe returns ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Host serial clock, asynchronous, idles high |
| latch_i | input | 1 | Host latch strobe, asynchronous, idles high |
| din_i | input | 1 | Host serial command data |
| rdy_o | output | 1 | Ready; low means the host must wait |
| dout_o | output | 1 | Serial read data |
| dout_oe_o | output | 1 | Enable for the data-out driver |
| seq_err_o | output | 1 | One-cycle pulse on a latch fall during readout |
| mem_req_o | output | 1 | One-cycle fetch request to internal storage |
| mem_addr_o | output | ADDR_W | Fetch address |
| mem_tsel_o | output | 1 | Fetch target, 1 = setup register |
| mem_vld_i | input | 1 | Storage read data valid |
| mem_data_i | input | DATA_W | Storage read data |

## Verification
The bench reads every address of both targets with storage latency swept from 1 to 8 cycles. A length decode error would show up as a truncated or overlong word, and reversed bit order as a mirrored word. Every other read carries the next command in its final bits. A port that clears or ignores its command register during readout would fetch the wrong address on the following strobe. One read sees a serial clock cycle during a long fetch, which catches an output that advances before ready is high. Another lowers the latch strobe mid-word: a missing error pulse, or a pulse raised on legal strobes, is counted against R9.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } srp_state_e;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int           W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q <= RST_VAL[gi];
        s2_q <= RST_VAL[gi];
      end else begin
        s1_q <= async_i[gi];
        s2_q <= s1_q;
      end
    end
    assign sync_o[gi] = s2_q;
  end
endmodule

// File: rtl/srp_cmd_shift.sv
module srp_cmd_shift #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en_i,
  input  logic             bit_i,
  output logic [CMD_W-1:0] cmd_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o <= '0;
    end else if (shift_en_i) begin
      cmd_o <= {cmd_o[CMD_W-2:0], bit_i};
    end
  end
endmodule

// File: rtl/srp_tx_shift.sv
module srp_tx_shift #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              step_i,
  output logic              dout_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      dout_o <= 1'b0;
    end else if (load_i) begin
      sh_q  <= data_i;
      cnt_q <= len_i;
    end else if (step_i && (cnt_q != '0)) begin
      dout_o <= sh_q[0];
      sh_q   <= {1'b0, sh_q[DATA_W-1:1]};
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 24,
  parameter int COEF_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_rise_i,
  input  logic              latch_fall_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              cmd_rd_i,
  input  logic              cmd_tsel_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              mem_vld_i,
  input  logic              tx_empty_i,
  output logic              rdy_o,
  output logic              oe_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              tsel_o,
  output logic              err_o,
  output logic              tx_load_o,
  output logic [CNT_W-1:0]  tx_len_o,
  output logic              tx_step_o
);
  srp_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rdy_o   <= 1'b1;
      oe_o    <= 1'b0;
      req_o   <= 1'b0;
      addr_o  <= '0;
      tsel_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      req_o <= 1'b0;
      err_o <= 1'b0;
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (latch_rise_i && cmd_rd_i) begin
            state_q <= ST_FETCH;
            rdy_o   <= 1'b0;
            oe_o    <= 1'b1;
            req_o   <= 1'b1;
            addr_o  <= cmd_addr_i;
            tsel_o  <= cmd_tsel_i;
          end else if ((state_q == ST_DONE) && latch_fall_i) begin
            state_q <= ST_IDLE;
            rdy_o   <= 1'b1;
          end
        end
        ST_FETCH: begin
          if (mem_vld_i) begin
            state_q <= ST_SHIFT;
            rdy_o   <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (latch_fall_i) begin
            err_o <= 1'b1;
          end
          if (sclk_rise_i && tx_empty_i) begin
            state_q <= ST_DONE;
            rdy_o   <= 1'b0;
            oe_o    <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_load_o = (state_q == ST_FETCH) && mem_vld_i;
  assign tx_step_o = (state_q == ST_SHIFT) && sclk_fall_i;
  assign tx_len_o  = tsel_o ? CNT_W'(DATA_W) : CNT_W'(COEF_W);
endmodule

// File: rtl/srp_read_port.sv
module srp_read_port #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 24,
  parameter int COEF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              latch_i,
  input  logic              din_i,
  output logic              rdy_o,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              seq_err_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_tsel_o,
  input  logic              mem_vld_i,
  input  logic [DATA_W-1:0] mem_data_i
);
  localparam int CMD_W = ADDR_W + 2;
  localparam int CNT_W = $clog2(DATA_W + 1);

  // synchronized vector: [0] serial clock, [1] latch strobe, [2] data-in
  logic [2:0] sync_w;
  logic [1:0] ctl_prev_q;
  logic       sclk_rise_w, sclk_fall_w, latch_rise_w, latch_fall_w;
  logic [CMD_W-1:0] cmd_w;
  logic             tx_load_w, tx_step_w, tx_empty_w;
  logic [CNT_W-1:0] tx_len_w;

  srp_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({din_i, latch_i, sclk_i}),
    .sync_o  (sync_w)
  );

  always_ff @(posedge clk) begin
    if (rst) ctl_prev_q <= 2'b11;
    else     ctl_prev_q <= sync_w[1:0];
  end

  assign sclk_rise_w  =  sync_w[0] & ~ctl_prev_q[0];
  assign sclk_fall_w  = ~sync_w[0] &  ctl_prev_q[0];
  assign latch_rise_w =  sync_w[1] & ~ctl_prev_q[1];
  assign latch_fall_w = ~sync_w[1] &  ctl_prev_q[1];

  srp_cmd_shift #(.CMD_W(CMD_W)) u_cmd (
    .clk        (clk),
    .rst        (rst),
    .shift_en_i (sclk_rise_w),
    .bit_i      (sync_w[2]),
    .cmd_o      (cmd_w)
  );

  srp_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .latch_rise_i (latch_rise_w),
    .latch_fall_i (latch_fall_w),
    .sclk_rise_i  (sclk_rise_w),
    .sclk_fall_i  (sclk_fall_w),
    .cmd_rd_i     (cmd_w[CMD_W-1]),
    .cmd_tsel_i   (cmd_w[CMD_W-2]),
    .cmd_addr_i   (cmd_w[ADDR_W-1:0]),
    .mem_vld_i    (mem_vld_i),
    .tx_empty_i   (tx_empty_w),
    .rdy_o        (rdy_o),
    .oe_o         (dout_oe_o),
    .req_o        (mem_req_o),
    .addr_o       (mem_addr_o),
    .tsel_o       (mem_tsel_o),
    .err_o        (seq_err_o),
    .tx_load_o    (tx_load_w),
    .tx_len_o     (tx_len_w),
    .tx_step_o    (tx_step_w)
  );

  srp_tx_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .load_i  (tx_load_w),
    .len_i   (tx_len_w),
    .data_i  (mem_data_i),
    .step_i  (tx_step_w),
    .dout_o  (dout_o),
    .empty_o (tx_empty_w)
  );
endmodule

// File: rtl/srp_read_port_chk.sv
module srp_read_port_chk (
  input logic clk,
  input logic rst,
  input logic rdy_o,
  input logic dout_o,
  input logic dout_oe_o,
  input logic seq_err_o,
  input logic mem_req_o,
  input logic mem_vld_i
);
  // R2
  oe_with_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_oe_o) |-> !rdy_o);

  // R3
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !mem_req_o);

  // R3
  req_during_wait_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (dout_oe_o && !rdy_o));

  // R4
  rdy_after_vld_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rdy_o) && dout_oe_o) |-> $past(mem_vld_i));

  // R5
  dout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout_o) |-> dout_oe_o);

  // R7
  release_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dout_oe_o) |-> !rdy_o);

  // R9
  err_in_shift_chk: assert property (@(posedge clk) disable iff (rst)
    seq_err_o |-> ($past(rdy_o) && $past(dout_oe_o)));
endmodule

bind srp_read_port srp_read_port_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rdy_o     (rdy_o),
  .dout_o    (dout_o),
  .dout_oe_o (dout_oe_o),
  .seq_err_o (seq_err_o),
  .mem_req_o (mem_req_o),
  .mem_vld_i (mem_vld_i)
);

// File: tb/srp_read_port_tb_top.sv
`timescale 1ns/1ps
module srp_read_port_tb_top;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 24;
  localparam int COEF_W = 16;
  localparam int CMD_W  = ADDR_W + 2;

  logic clk = 1'b0;
  logic rst;
  logic sclk, latch, din;
  logic rdy_o, dout_o, dout_oe_o, seq_err_o, mem_req_o, mem_tsel_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic mem_vld;
  logic [DATA_W-1:0] mem_data;

  int checks = 0, failures = 0;
  int req_cnt = 0, err_cnt = 0, cur_lat = 1, pend = 0;
  logic [ADDR_W-1:0] p_addr;
  logic p_sel;

  always #10 clk = ~clk;

  srp_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COEF_W(COEF_W)) dut_i (
    .clk(clk), .rst(rst), .sclk_i(sclk), .latch_i(latch), .din_i(din),
    .rdy_o(rdy_o), .dout_o(dout_o), .dout_oe_o(dout_oe_o), .seq_err_o(seq_err_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_tsel_o(mem_tsel_o),
    .mem_vld_i(mem_vld), .mem_data_i(mem_data)
  );

  function automatic logic [DATA_W-1:0] mem_word(input logic s, input logic [ADDR_W-1:0] a);
    logic [31:0] t;
    t = ((32'(a) + 32'd1) * 32'h0009E3B7) ^ (s ? 32'h00C35A96 : 32'h0);
    return t[DATA_W-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // storage model with latency cur_lat, plus pulse monitors
  always @(negedge clk) begin
    if (!rst) begin
      if (seq_err_o) err_cnt++;
      if (mem_vld) begin
        chk(rdy_o && dout_oe_o, "R4 ready high after valid", rdy_o, 1);
        mem_vld = 1'b0;
      end
      if (mem_req_o) begin
        req_cnt++;
        pend = cur_lat;
        p_addr = mem_addr_o;
        p_sel = mem_tsel_o;
      end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          chk(!rdy_o, "R4 ready low until valid", rdy_o, 0);
          mem_vld = 1'b1;
          mem_data = mem_word(p_sel, p_addr);
        end
      end
    end
  end

  task automatic sbit(input logic b, output logic o);
    sclk = 1'b0; din = b;
    repeat (4) @(negedge clk);
    o = dout_o;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic shift_cmd(input logic [CMD_W-1:0] c);
    logic dummy;
    for (int i = CMD_W - 1; i >= 0; i--) sbit(c[i], dummy);
  endtask

  task automatic start_xfer();
    latch = 1'b0;
    repeat (4) @(negedge clk);
    chk(rdy_o === 1'b1, "R11 ready high after strobe fall", rdy_o, 1);
  endtask

  task automatic strobe_read(input logic s, input logic [ADDR_W-1:0] a, input string tag);
    latch = 1'b1;
    repeat (2) @(negedge clk);
    chk(rdy_o === 1'b1, "R2 ready not early", rdy_o, 1);
    @(negedge clk);
    chk(!rdy_o && dout_oe_o, "R2 ready low with enable", {rdy_o, dout_oe_o}, 2'b01);
    chk(mem_req_o && mem_addr_o == a && mem_tsel_o == s, tag,
        {mem_req_o, mem_tsel_o, mem_addr_o}, {1'b1, s, a});
  endtask

  task automatic wait_rdy();
    int n = 0;
    while (!rdy_o && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(rdy_o === 1'b1, "R4 ready returns", rdy_o, 1);
  endtask

  task automatic read_word(input logic s, input logic [ADDR_W-1:0] a, input bit ov,
                           input logic [CMD_W-1:0] nxt, input int viol_at, input string tag);
    int len;
    logic [DATA_W-1:0] got, exp;
    logic o, b;
    len = s ? DATA_W : COEF_W;
    got = '0;
    for (int i = 0; i < len; i++) begin
      if (i == viol_at) begin
        int e0 = err_cnt;
        latch = 1'b0;
        repeat (4) @(negedge clk);
        chk(err_cnt == e0 + 1, "R9 error on fall during readout", err_cnt, e0 + 1);
      end
      b = (ov && i >= len - CMD_W) ? nxt[len - 1 - i] : 1'b0;
      sbit(b, o);
      got[i] = o;
    end
    exp = mem_word(s, a);
    if (!s) exp = exp & DATA_W'((1 << COEF_W) - 1);
    chk(got == exp, tag, got, exp);
    chk(!rdy_o && !dout_oe_o, "R7 end of read", {rdy_o, dout_oe_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic pre;
    logic o;
    rst = 1'b1; sclk = 1'b1; latch = 1'b1; din = 1'b0;
    mem_vld = 1'b0; mem_data = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rdy_o && !dout_oe_o && !mem_req_o && !seq_err_o, "R1 reset state",
        {rdy_o, dout_oe_o, mem_req_o, seq_err_o}, 4'b1000);

    // R10: write command ignored
    begin
      int r0;
      start_xfer();
      r0 = req_cnt;
      shift_cmd({1'b0, 1'b1, 6'd5});
      latch = 1'b1;
      repeat (12) @(negedge clk);
      chk(rdy_o && !dout_oe_o && req_cnt == r0, "R10 write ignored",
          {rdy_o, dout_oe_o, 8'(req_cnt - r0)}, 10'h200);
    end

    // R3 R5 R8: sweep both targets, all addresses, latency 1..8
    pre = 1'b0;
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < (1 << ADDR_W); a++) begin
        bit ov;
        logic [CMD_W-1:0] nxt;
        cur_lat = (a % 8) + 1;
        ov = (a % 2 == 0) && (a != (1 << ADDR_W) - 1);
        nxt = {1'b1, 1'(s), ADDR_W'(a + 1)};
        start_xfer();
        if (!pre) shift_cmd({1'b1, 1'(s), ADDR_W'(a)});
        strobe_read(1'(s), ADDR_W'(a), pre ? "R8 overlapped command" : "R3 request fields");
        wait_rdy();
        read_word(1'(s), ADDR_W'(a), ov, nxt, -1, s ? "R5 setup word" : "R5 coefficient word");
        pre = ov;
      end
    end

    // R6: serial clock cycle during a long fetch does not advance output
    cur_lat = 30;
    start_xfer();
    shift_cmd({1'b1, 1'b1, 6'd9});
    strobe_read(1'b1, 6'd9, "R3 request fields");
    sbit(1'b1, o);
    chk(!rdy_o, "R6 still waiting", rdy_o, 0);
    wait_rdy();
    read_word(1'b1, 6'd9, 1'b0, '0, -1, "R6 first bit after ready");

    // R9: latch falls during readout
    cur_lat = 2;
    start_xfer();
    shift_cmd({1'b1, 1'b0, 6'd33});
    strobe_read(1'b0, 6'd33, "R3 request fields");
    wait_rdy();
    read_word(1'b0, 6'd33, 1'b0, '0, 3, "R9 word intact after violation");
    latch = 1'b1;
    repeat (4) @(negedge clk);
    start_xfer();
    chk(err_cnt == 1, "R9 no flag on legal strobes", err_cnt, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule